// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block decides which digital peripheral signal appears on each of 24 physical pins. The pins form three 8-bit ports and are scanned from port 0 bit 0 up to port 2 bit 7. The inputs are a set of peripheral enables, one skip mask per port, and a 2-bit field that selects between three-wire and four-wire SPI. Enabled signals are placed in a fixed priority order. Each signal takes the lowest pin that is neither skipped nor already taken. The two UART signals are the exception: they always occupy two fixed pins.

For every pin the block reports a 5-bit function code, where all ones means plain GPIO. For every signal it reports the pin it landed on and a valid flag. Pins used by analog or crystal functions are kept away from the allocator by setting their skip bits. For example, a port 1 skip mask of 0x03 keeps both crystal pins free of digital functions.

The configuration is registered on one clock edge and the pin map is registered on the next.

Top module: `pin_crossbar`

## Requirements
- R1: Function codes and priority, highest first, are: 0 UART TX, 1 UART RX, 2 SCK, 3 MISO, 4 MOSI, 5 NSS, 6 SDA, 7 SCL, 8 CP0, 9 CP0A, 10 CP1, 11 CP1A, 12 system clock out, 13..18 PCA channels 0..5, 19 PCA external clock, 20 T0, 21 T1. Pin index is port*8+bit. Each non-UART enabled signal takes the lowest free pin that lower-numbered signals have left, and no code appears on more than one pin.
- R2: With `uartEn` high, TX (code 0) sits on pin 4 and RX (code 1) sits on pin 5 whatever the skip masks say, and no other signal may use those pins. With `uartEn` low, pins 4 and 5 are ordinary pins.
- R3: `spiEn` requests SCK, MISO and MOSI. NSS is requested only when `nssMode` is not 2'b00. With 2'b00 (three-wire) NSS takes no pin and the signals after it move up.
- R4: `smbEn` requests SDA and SCL as a pair. The pair is placed only if at least two free pins remain when SDA is reached; otherwise both stay unplaced, and lower-priority signals may still use the remaining pins.
- R5: A pin whose skip bit is 1 (skipMask0 bit b = pin b, skipMask1 bit b = pin 8+b, skipMask2 bit b = pin 16+b) never carries a peripheral function and reads code 31. The only exception is the fixed UART pins while `uartEn` is high.
- R6: An enabled signal that finds no free pin has its valid flag at 0 and its pin index at 0.
- R7: Every pin not carrying a peripheral reads code 31 (GPIO).
- R8: For each signal i, `sigValid[i]` is 1 exactly when it was placed, and `sigPin[5i+:5]` then names a pin whose code is i.
- R9: Inputs present at clock edge k are reflected at the outputs right after edge k+1 and not before. While `rst` is high the outputs show every pin at code 31, all valid flags at 0 and all pin indices at 0.
- R10: `pcaCount` = N enables PCA channels 0..N-1. Values of 6 and 7 enable all six channels.
- R11: Bit j of `cmpEn` enables, in turn, CP0 (j=0), CP0A (1), CP1 (2) and CP1A (3). Bit 0 of `timerEn` enables T0 and bit 1 enables T1. `sysClkOutEn` and `eciEn` each enable one signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uartEn | input | 1 | Enable UART TX/RX pair |
| spiEn | input | 1 | Enable SPI |
| nssMode | input | 2 | 2'b00 three-wire, otherwise four-wire |
| smbEn | input | 1 | Enable SDA/SCL pair |
| cmpEn | input | 4 | Comparator output enables |
| sysClkOutEn | input | 1 | Enable system clock output |
| pcaCount | input | 3 | Number of PCA channels routed |
| eciEn | input | 1 | Enable PCA external clock input |
| timerEn | input | 2 | Timer input enables |
| skipMask0 | input | 8 | Skip mask, port 0 |
| skipMask1 | input | 8 | Skip mask, port 1 |
| skipMask2 | input | 8 | Skip mask, port 2 |
| pinFunc | output | 120 | Per-pin function code, pin p at bits 5p+:5 |
| sigPin | output | 110 | Per-signal pin index, signal i at bits 5i+:5 |
| sigValid | output | 22 | Per-signal placed flag |

## Verification
Every result in the map is due exactly two rising edges after the inputs are driven: one edge captures the configuration, the next captures the computed map. The driver drives a configuration on a falling edge and queues its expected map tagged with the cycle count two edges ahead. It also queues the previous map one edge ahead, which checks that nothing arrives early. The monitor compares only the items whose due count matches the current cycle, a moment after each falling edge, so every comparison falls on a settled register output.

// File: rtl/pin_crossbar_pkg.sv
package pin_crossbar_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 3;
  localparam int NUM_PINS  = PORT_W * NUM_PORTS;
  localparam int NUM_SIGS  = 22;
  localparam int CODE_W    = 5;
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int NUM_CMP   = 4;
  localparam int NUM_PCA   = 6;
  localparam int PCA_W     = 3;
  localparam int NUM_TMR   = 2;
  localparam logic [CODE_W-1:0] GPIO_CODE = '1;

  // signal codes, in priority order
  localparam int SIG_TX    = 0;
  localparam int SIG_RX    = 1;
  localparam int SIG_SCK   = 2;
  localparam int SIG_MISO  = 3;
  localparam int SIG_MOSI  = 4;
  localparam int SIG_NSS   = 5;
  localparam int SIG_SDA   = 6;
  localparam int SIG_SCL   = 7;
  localparam int SIG_CMP0  = 8;
  localparam int SIG_SYSCK = 12;
  localparam int SIG_PCA0  = 13;
  localparam int SIG_ECI   = 19;
  localparam int SIG_TMR0  = 20;

  localparam int TX_PIN = 4;
  localparam int RX_PIN = 5;

  typedef struct packed {
    logic                 uartEn;
    logic                 spiEn;
    logic [1:0]           nssMode;
    logic                 smbEn;
    logic [NUM_CMP-1:0]   cmpEn;
    logic                 sysClkOutEn;
    logic [PCA_W-1:0]     pcaCount;
    logic                 eciEn;
    logic [NUM_TMR-1:0]   timerEn;
    logic [NUM_PINS-1:0]  skip;
  } cfg_t;

  typedef struct packed {
    logic cfgLoad;
    logic mapLoad;
  } strobe_t;
endpackage

// File: rtl/pin_crossbar_ctrl.sv
module pin_crossbar_ctrl
  import pin_crossbar_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t strb
);
  logic cfgHeld;

  always_ff @(posedge clk) begin
    if (rst) cfgHeld <= 1'b0;
    else     cfgHeld <= 1'b1;
  end

  always_comb begin
    strb.cfgLoad = !rst;
    strb.mapLoad = cfgHeld && !rst;
  end
endmodule

// File: rtl/pin_crossbar_datapath.sv
module pin_crossbar_datapath
  import pin_crossbar_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  cfg_t                cfgIn,
  input  strobe_t             strb,
  output logic [CODE_W-1:0]   funcQ [NUM_PINS],
  output logic [PIN_W-1:0]    pinQ  [NUM_SIGS],
  output logic [NUM_SIGS-1:0] validQ
);
  cfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (rst)               cfgQ <= '0;
    else if (strb.cfgLoad) cfgQ <= cfgIn;
  end

  function automatic logic [PIN_W:0] firstFree(input logic [NUM_PINS-1:0] m);
    logic [PIN_W:0] r;
    r = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--)
      if (m[p]) r = {1'b1, PIN_W'(p)};
    return r;
  endfunction

  logic [NUM_SIGS-1:0] req;
  logic [NUM_PINS-1:0] freeMask;
  logic [CODE_W-1:0]   nextFunc [NUM_PINS];
  logic [PIN_W-1:0]    nextPin  [NUM_SIGS];
  logic [NUM_SIGS-1:0] nextValid;
  logic                smbOk;
  logic [PIN_W:0]      pick;

  always_comb begin
    req = '0;
    req[SIG_SCK]  = cfgQ.spiEn;
    req[SIG_MISO] = cfgQ.spiEn;
    req[SIG_MOSI] = cfgQ.spiEn;
    req[SIG_NSS]  = cfgQ.spiEn && (cfgQ.nssMode != 2'b00);
    req[SIG_SDA]  = cfgQ.smbEn;
    req[SIG_SCL]  = cfgQ.smbEn;
    for (int c = 0; c < NUM_CMP; c++) req[SIG_CMP0 + c] = cfgQ.cmpEn[c];
    req[SIG_SYSCK] = cfgQ.sysClkOutEn;
    for (int c = 0; c < NUM_PCA; c++)
      req[SIG_PCA0 + c] = (int'(cfgQ.pcaCount) > c);
    req[SIG_ECI] = cfgQ.eciEn;
    for (int t = 0; t < NUM_TMR; t++) req[SIG_TMR0 + t] = cfgQ.timerEn[t];
  end

  always_comb begin
    freeMask  = ~cfgQ.skip;
    nextValid = '0;
    smbOk     = 1'b0;
    pick      = '0;
    for (int p = 0; p < NUM_PINS; p++) nextFunc[p] = GPIO_CODE;
    for (int s = 0; s < NUM_SIGS; s++) nextPin[s] = '0;

    if (cfgQ.uartEn) begin
      freeMask[TX_PIN]   = 1'b0;
      freeMask[RX_PIN]   = 1'b0;
      nextFunc[TX_PIN]   = CODE_W'(SIG_TX);
      nextFunc[RX_PIN]   = CODE_W'(SIG_RX);
      nextPin[SIG_TX]    = PIN_W'(TX_PIN);
      nextPin[SIG_RX]    = PIN_W'(RX_PIN);
      nextValid[SIG_TX]  = 1'b1;
      nextValid[SIG_RX]  = 1'b1;
    end

    for (int s = SIG_SCK; s < NUM_SIGS; s++) begin
      if (s == SIG_SDA) smbOk = ($countones(freeMask) >= 2);
      if (req[s] && ((s != SIG_SDA && s != SIG_SCL) || smbOk)) begin
        pick = firstFree(freeMask);
        if (pick[PIN_W]) begin
          freeMask[pick[PIN_W-1:0]] = 1'b0;
          nextFunc[pick[PIN_W-1:0]] = CODE_W'(s);
          nextPin[s]                = pick[PIN_W-1:0];
          nextValid[s]              = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) funcQ[p] <= GPIO_CODE;
      for (int s = 0; s < NUM_SIGS; s++) pinQ[s] <= '0;
      validQ <= '0;
    end else if (strb.mapLoad) begin
      for (int p = 0; p < NUM_PINS; p++) funcQ[p] <= nextFunc[p];
      for (int s = 0; s < NUM_SIGS; s++) pinQ[s] <= nextPin[s];
      validQ <= nextValid;
    end
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import pin_crossbar_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         uartEn,
  input  logic                         spiEn,
  input  logic [1:0]                   nssMode,
  input  logic                         smbEn,
  input  logic [NUM_CMP-1:0]           cmpEn,
  input  logic                         sysClkOutEn,
  input  logic [PCA_W-1:0]             pcaCount,
  input  logic                         eciEn,
  input  logic [NUM_TMR-1:0]           timerEn,
  input  logic [PORT_W-1:0]            skipMask0,
  input  logic [PORT_W-1:0]            skipMask1,
  input  logic [PORT_W-1:0]            skipMask2,
  output logic [NUM_PINS*CODE_W-1:0]   pinFunc,
  output logic [NUM_SIGS*PIN_W-1:0]    sigPin,
  output logic [NUM_SIGS-1:0]          sigValid
);
  cfg_t                cfgIn;
  strobe_t             strb;
  logic [CODE_W-1:0]   funcQ [NUM_PINS];
  logic [PIN_W-1:0]    pinQ  [NUM_SIGS];

  always_comb begin
    cfgIn.uartEn      = uartEn;
    cfgIn.spiEn       = spiEn;
    cfgIn.nssMode     = nssMode;
    cfgIn.smbEn       = smbEn;
    cfgIn.cmpEn       = cmpEn;
    cfgIn.sysClkOutEn = sysClkOutEn;
    cfgIn.pcaCount    = pcaCount;
    cfgIn.eciEn       = eciEn;
    cfgIn.timerEn     = timerEn;
    cfgIn.skip        = {skipMask2, skipMask1, skipMask0};
  end

  pin_crossbar_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  pin_crossbar_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .cfgIn  (cfgIn),
    .strb   (strb),
    .funcQ  (funcQ),
    .pinQ   (pinQ),
    .validQ (sigValid)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pinOut
    assign pinFunc[p*CODE_W +: CODE_W] = funcQ[p];
  end
  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sigOut
    assign sigPin[s*PIN_W +: PIN_W] = pinQ[s];
  end
endmodule

// File: rtl/pin_crossbar_checker.sv
module pin_crossbar_checker
  import pin_crossbar_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       uartEn,
  input logic                       spiEn,
  input logic [1:0]                 nssMode,
  input logic [PORT_W-1:0]          skipMask0,
  input logic [PORT_W-1:0]          skipMask1,
  input logic [PORT_W-1:0]          skipMask2,
  input logic [NUM_PINS*CODE_W-1:0] pinFunc,
  input logic [NUM_SIGS*PIN_W-1:0]  sigPin,
  input logic [NUM_SIGS-1:0]        sigValid
);
  logic [1:0]          warm;
  logic [NUM_PINS-1:0] skipAll;
  logic [CODE_W-1:0]   funcArr [NUM_PINS];

  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign skipAll = {skipMask2, skipMask1, skipMask0};
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_unpack
    assign funcArr[p] = pinFunc[p*CODE_W +: CODE_W];
  end

  assert_uart_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(uartEn, 2)) |->
      (funcArr[TX_PIN] == CODE_W'(SIG_TX) && funcArr[RX_PIN] == CODE_W'(SIG_RX)));

  assert_nss_absent_R3: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && (!$past(spiEn, 2) || $past(nssMode, 2) == 2'b00)) |->
      !sigValid[SIG_NSS]);

  assert_smb_pair_R4: assert property (@(posedge clk) disable iff (rst)
    sigValid[SIG_SDA] == sigValid[SIG_SCL]);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_skip
    localparam bit FIXED = (p == TX_PIN) || (p == RX_PIN);
    assert_skip_gpio_R5: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(skipAll[p], 2) && !(FIXED && $past(uartEn, 2))) |->
        funcArr[p] == GPIO_CODE);
  end

  for (genvar f = 0; f < NUM_SIGS; f++) begin : g_code
    logic [NUM_PINS-1:0] hit;
    always_comb
      for (int p = 0; p < NUM_PINS; p++) hit[p] = (funcArr[p] == CODE_W'(f));
    assert_code_unique_R1: assert property (@(posedge clk) disable iff (rst)
      $countones(hit) <= 1);
    assert_sig_map_R8: assert property (@(posedge clk) disable iff (rst)
      sigValid[f] |->
        (int'(sigPin[f*PIN_W +: PIN_W]) < NUM_PINS &&
         funcArr[sigPin[f*PIN_W +: PIN_W]] == CODE_W'(f)));
    assert_unplaced_pin_R6: assert property (@(posedge clk) disable iff (rst)
      !sigValid[f] |-> sigPin[f*PIN_W +: PIN_W] == '0);
  end
endmodule

bind pin_crossbar pin_crossbar_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .uartEn    (uartEn),
  .spiEn     (spiEn),
  .nssMode   (nssMode),
  .skipMask0 (skipMask0),
  .skipMask1 (skipMask1),
  .skipMask2 (skipMask2),
  .pinFunc   (pinFunc),
  .sigPin    (sigPin),
  .sigValid  (sigValid)
);

// File: tb/tb_pin_crossbar.sv
`timescale 1ns/1ps
module tb_pin_crossbar;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uartEn = 0, spiEn = 0, smbEn = 0, sysClkOutEn = 0, eciEn = 0;
  logic [1:0] nssMode = 0, timerEn = 0;
  logic [3:0] cmpEn = 0;
  logic [2:0] pcaCount = 0;
  logic [7:0] skipMask0 = 0, skipMask1 = 0, skipMask2 = 0;
  logic [119:0] pinFunc;
  logic [109:0] sigPin;
  logic [21:0]  sigValid;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int           due;
    logic [119:0] func;
    logic [109:0] pin;
    logic [21:0]  valid;
    string        tag;
  } item_t;
  item_t q[$];
  item_t prevExp;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_crossbar dut (
    .clk(clk), .rst(rst), .uartEn(uartEn), .spiEn(spiEn), .nssMode(nssMode),
    .smbEn(smbEn), .cmpEn(cmpEn), .sysClkOutEn(sysClkOutEn), .pcaCount(pcaCount),
    .eciEn(eciEn), .timerEn(timerEn), .skipMask0(skipMask0), .skipMask1(skipMask1),
    .skipMask2(skipMask2), .pinFunc(pinFunc), .sigPin(sigPin), .sigValid(sigValid)
  );

  // Reference: walk the pins and hand out the requested list in priority order.
  task automatic refModel(input logic u, s, input logic [1:0] nm, input logic smb,
                          input logic [3:0] cmp, input logic sys, input logic [2:0] pca,
                          input logic eci, input logic [1:0] tmr,
                          input logic [7:0] k0, k1, k2, inout item_t e);
    int ids[$];
    bit avail[24];
    logic [23:0] sk;
    int k, rem, n;
    sk = {k2, k1, k0};
    e.func = '1; e.pin = '0; e.valid = '0;
    if (s) begin ids.push_back(2); ids.push_back(3); ids.push_back(4); end
    if (s && nm != 2'b00) ids.push_back(5);
    if (smb) begin ids.push_back(6); ids.push_back(7); end
    for (int j = 0; j < 4; j++) if (cmp[j]) ids.push_back(8 + j);
    if (sys) ids.push_back(12);
    n = (pca > 3'd6) ? 6 : int'(pca);
    for (int j = 0; j < n; j++) ids.push_back(13 + j);
    if (eci) ids.push_back(19);
    for (int j = 0; j < 2; j++) if (tmr[j]) ids.push_back(20 + j);
    for (int p = 0; p < 24; p++) avail[p] = !sk[p] && !(u && (p == 4 || p == 5));
    if (u) begin
      e.func[4*5 +: 5] = 5'd0; e.func[5*5 +: 5] = 5'd1;
      e.pin[0 +: 5] = 5'd4;     e.pin[5 +: 5] = 5'd5;
      e.valid[0] = 1'b1;        e.valid[1] = 1'b1;
    end
    k = 0;
    for (int p = 0; p < 24; p++) begin
      if (!avail[p]) continue;
      rem = 0;
      for (int r = p; r < 24; r++) if (avail[r]) rem++;
      if (k < ids.size() && ids[k] == 6 && rem < 2) k += 2;
      if (k < ids.size()) begin
        e.func[p*5 +: 5] = 5'(ids[k]);
        e.pin[ids[k]*5 +: 5] = 5'(p);
        e.valid[ids[k]] = 1'b1;
        k++;
      end
    end
  endtask

  task automatic apply(input logic u, s, input logic [1:0] nm, input logic smb,
                       input logic [3:0] cmp, input logic sys, input logic [2:0] pca,
                       input logic eci, input logic [1:0] tmr,
                       input logic [7:0] k0, k1, k2, input string tag);
    item_t e, early;
    @(negedge clk);
    uartEn = u; spiEn = s; nssMode = nm; smbEn = smb; cmpEn = cmp;
    sysClkOutEn = sys; pcaCount = pca; eciEn = eci; timerEn = tmr;
    skipMask0 = k0; skipMask1 = k1; skipMask2 = k2;
    refModel(u, s, nm, smb, cmp, sys, pca, eci, tmr, k0, k1, k2, e);
    early = prevExp;
    early.due = cyc + 1;
    early.tag = {"R9 early/", tag};
    q.push_back(early);
    e.due = cyc + 2;
    e.tag = tag;
    q.push_back(e);
    prevExp = e;
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (pinFunc !== it.func || sigPin !== it.pin || sigValid !== it.valid) begin
        bad++;
        $display("FAIL %s: func=%h/%h pin=%h/%h valid=%h/%h (actual/expected)",
                 it.tag, pinFunc, it.func, sigPin, it.pin, sigValid, it.valid);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    prevExp.func = '1; prevExp.pin = '0; prevExp.valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (pinFunc !== '1 || sigPin !== '0 || sigValid !== '0) begin
      bad++;
      $display("FAIL R9 reset: func=%h pin=%h valid=%h expected all-ones/0/0",
               pinFunc, sigPin, sigValid);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R7: nothing enabled, all pins GPIO
    apply(0,0,0,0,4'h0,0,0,0,2'b00, 8'h00,8'h00,8'h00, "R7 idle");
    // R2: UART pins fixed even when their skip bits are set
    apply(1,0,0,0,4'h0,0,0,0,2'b00, 8'h30,8'h00,8'h00, "R2 uart skip ignored");
    apply(1,1,2'b01,0,4'h0,0,0,0,2'b00, 8'hCF,8'hFF,8'h00, "R2 uart heavy skip");
    // R3: three-wire vs four-wire
    apply(0,1,2'b00,1,4'h0,0,0,0,2'b00, 8'h00,8'h00,8'h00, "R3 three-wire");
    apply(0,1,2'b10,1,4'h0,0,0,0,2'b00, 8'h00,8'h00,8'h00, "R3 four-wire");
    apply(1,1,2'b01,0,4'h0,0,0,0,2'b00, 8'h00,8'h00,8'h00, "R3 four-wire with uart");
    // R5: crystal pins reserved
    apply(1,1,2'b01,1,4'hF,1,3'd6,1,2'b11, 8'h01,8'h03,8'h00, "R5 crystal skip");
    // R1: everything enabled, nothing skipped
    apply(1,1,2'b11,1,4'hF,1,3'd6,1,2'b11, 8'h00,8'h00,8'h00, "R1 full load");
    // R4: pair dropped, later single uses last pin
    apply(0,1,2'b00,1,4'h1,0,0,0,2'b00, 8'hF0,8'hFF,8'hFF, "R4 pair dropped");
    apply(0,0,2'b00,1,4'h1,1,0,0,2'b00, 8'hF8,8'hFF,8'hFF, "R4 R6 pair fits then exhausted");
    // R6: exhaustion
    apply(1,1,2'b01,1,4'hF,1,3'd7,1,2'b11, 8'hFF,8'hFF,8'hFC, "R6 exhausted");
    // R10: PCA channel counts
    apply(0,0,0,0,4'h0,0,3'd3,1,2'b00, 8'h00,8'h00,8'h00, "R10 pca three");
    apply(0,0,0,0,4'h0,0,3'd7,0,2'b00, 8'h00,8'h00,8'h00, "R10 pca saturate");
    // R11: individual comparator and timer bits
    apply(0,0,0,0,4'h4,0,0,0,2'b10, 8'h00,8'h00,8'h00, "R11 cp1 t1");
    apply(0,0,0,0,4'hA,1,0,1,2'b01, 8'h05,8'h00,8'h00, "R11 cp0a cp1a sys eci t0");
    // R8: random configurations against the reference
    for (int n = 0; n < 80; n++) begin
      logic [31:0] r, m0, m1;
      r = $urandom; m0 = $urandom & $urandom; m1 = $urandom & $urandom & $urandom;
      apply(r[0], r[1], r[3:2], r[4], r[8:5], r[9], r[12:10], r[13], r[15:14],
            m0[7:0], m0[15:8] | m1[7:0], m0[23:16] | m1[15:8], "R8 random");
    end
    repeat (4) @(negedge clk);
    #2;
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 pending: actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule